// File: doc/BRIEF.md
# Floating-Point Compare-to-Mask Unit

This block compares two IEEE-754 operands, either both single precision or both double precision, and returns the outcome as a full-width mask. Each strobe carries a precision select and a 5-bit condition code. The code selects one of 22 predicates:

- always-false;
- unordered;
- equality, less-than and less-or-equal;
- the unordered-inclusive forms of those three;
- the complements of unordered, equality and unordered-equality.

For every predicate there is a quiet form and a signalling form. They differ only in which NaN inputs raise the invalid-operation flag.

A single-precision operand sits in the low 32 bits of its 64-bit port, and the upper half is ignored. Every result is registered and appears one cycle after the input strobe, together with a result-valid pulse. A write-enable output tells the surrounding datapath whether to store the mask. An unused code stops that write and raises an illegal flag. An invalid-operation indication is also accumulated into a sticky flag, which only reset clears.

Top module: `fp_mask_compare`

## Requirements
- R1: `res_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. When `res_valid` is low, `res_we`, `res_illegal` and `res_invalid` are also low.
- R2: When the predicate is true, `res_mask` is 64 ones for double precision (`in_dbl`=1) and 32 ones in bits 31:0 with bits 63:32 zero for single precision (`in_dbl`=0). When the predicate is false, `res_mask` is all zeros.
- R3: Codes 1, 2, 4 and 6 give unordered, equal, less-than and less-or-equal (a relative to b). Codes 9, 10, 12 and 14 give the same results. +0 and -0 compare equal, and every ordered relation is false when either operand is a NaN.
- R4: Ordering follows signed value. A negative operand is below a positive one, and of two negative operands the one with the larger magnitude is the smaller. Infinities and denormals are ordered by their value.
- R5: Codes 0 and 8 always give a zero mask with `res_we`=1, yet still raise invalid-operation according to their NaN rules.
- R6: Codes 3, 5 and 7, and codes 11, 13 and 15, give unordered OR equal, unordered OR less-than, and unordered OR less-or-equal.
- R7: Codes 17 and 25 are true when the operands are ordered. Codes 18 and 26 are true when the operands are unordered or unequal. Codes 19 and 27 are true only for ordered, unequal operands.
- R8: Codes 16, 20–24 and 28–31 are illegal. The result carries `res_illegal`=1, `res_we`=0 and `res_invalid`=0, and `res_mask` keeps its previous value.
- R9: Signalling codes (bit 3 of the code set: 8–15 and 25–27) raise `res_invalid` when either operand is any NaN.
- R10: Quiet codes (bit 3 clear: 0–7 and 17–19) raise `res_invalid` only when an operand is a signalling NaN.
- R11: `invalid_sticky` sets in the same cycle that `res_invalid` is high, and stays set until reset.
- R12: A NaN has an exponent of all ones and a nonzero fraction. It is signalling when the fraction's top bit is 0 and quiet when that bit is 1. In single-precision mode, bits 63:32 of the operands have no effect.
- R13: While `rst` is high, and after it is released, all outputs are zero until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compare request strobe |
| in_dbl | input | 1 | 1 = double precision, 0 = single precision |
| in_code | input | 5 | Condition code selecting the predicate |
| op_a | input | 64 | Left operand (single precision uses bits 31:0) |
| op_b | input | 64 | Right operand (single precision uses bits 31:0) |
| res_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| res_we | output | 1 | Mask should be written (legal code) |
| res_illegal | output | 1 | Code was not a valid compare code |
| res_invalid | output | 1 | Invalid-operation raised by this compare |
| res_mask | output | 64 | All-ones or all-zeros result mask |
| invalid_sticky | output | 1 | Accumulated invalid-operation flag |

## Verification
The properties assume the following about the inputs:

- `in_code` and `in_dbl` are meaningful only in a cycle where `in_valid` is high.
- Any input may change on any cycle, including back-to-back strobes.
- `rst` is synchronous.

The stimulus meets these assumptions by driving every input on the falling edge. It issues one request per step and mixes idle cycles with requests. It sweeps all 32 codes, in both precisions, across operand pairs drawn from:

- zeros of both signs;
- values of both signs;
- infinities of both signs;
- a denormal;
- quiet and signalling NaNs.

In single-precision steps, the upper operand halves carry a nonzero pattern.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  // Per-format comparison facts gathered for one operand pair.
  typedef struct packed {
    logic unord;     // at least one operand is a NaN
    logic any_nan;
    logic any_snan;
    logic lt;        // a < b, ordered only
    logic eq;        // a == b, ordered only
  } cmp_flags_t;

  // Code bits 2:1 pick the ordered relation, bit 0 ORs in unordered.
  typedef enum logic [1:0] {
    REL_NONE = 2'd0,
    REL_EQ   = 2'd1,
    REL_LT   = 2'd2,
    REL_LE   = 2'd3
  } rel_kind_t;

  localparam int CODE_W = 5;

  // Bit 4 selects the complement family, which uses only low codes 1..3.
  function automatic logic code_legal(input logic [CODE_W-1:0] c);
    return !c[4] || (!c[2] && (c[1:0] != 2'd0));
  endfunction

  function automatic logic eval_pred(input logic [CODE_W-1:0] c,
                                     input cmp_flags_t f);
    rel_kind_t rk;
    logic      rel_hit;
    logic      base;
    rk = rel_kind_t'(c[2:1]);
    unique case (rk)
      REL_NONE: rel_hit = 1'b0;
      REL_EQ:   rel_hit = f.eq;
      REL_LT:   rel_hit = f.lt;
      default:  rel_hit = f.lt | f.eq;
    endcase
    base = rel_hit | (c[0] & f.unord);
    return c[4] ? ~base : base;
  endfunction

  // Bit 3 selects signalling behaviour.
  function automatic logic eval_invalid(input logic [CODE_W-1:0] c,
                                        input cmp_flags_t f);
    return c[3] ? f.any_nan : f.any_snan;
  endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val,
  output logic         sign,
  output logic         is_nan,
  output logic         is_snan,
  output logic         is_zero,
  output logic [W-2:0] mag
);

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;

  always_comb begin
    expo    = val[W-2:FRAC_W];
    frac    = val[FRAC_W-1:0];
    sign    = val[W-1];
    mag     = val[W-2:0];
    is_nan  = (&expo) && (|frac);
    is_snan = is_nan && !frac[FRAC_W-1];
    is_zero = (mag == '0);
  end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int MAG_W = 31
) (
  input  logic             a_sign,
  input  logic             a_zero,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic             b_zero,
  input  logic [MAG_W-1:0] b_mag,
  output logic             lt,
  output logic             eq
);

  logic both_zero;
  logic mag_below;
  logic mag_above;

  always_comb begin
    both_zero = a_zero && b_zero;
    mag_below = a_mag < b_mag;
    mag_above = b_mag < a_mag;
    eq = both_zero || ((a_sign == b_sign) && (a_mag == b_mag));
    if (both_zero)             lt = 1'b0;
    else if (a_sign != b_sign) lt = a_sign;
    else if (!a_sign)          lt = mag_below;
    else                       lt = mag_above;
  end

endmodule

// File: rtl/fpcmp_lane.sv
module fpcmp_lane
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output cmp_flags_t   flags
);

  logic         a_sign, a_nan, a_snan, a_zero;
  logic         b_sign, b_nan, b_snan, b_zero;
  logic [W-2:0] a_mag, b_mag;
  logic         raw_lt, raw_eq;

  fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .val(a), .sign(a_sign), .is_nan(a_nan), .is_snan(a_snan),
    .is_zero(a_zero), .mag(a_mag)
  );

  fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .val(b), .sign(b_sign), .is_nan(b_nan), .is_snan(b_snan),
    .is_zero(b_zero), .mag(b_mag)
  );

  fpcmp_order #(.MAG_W(W-1)) u_ord (
    .a_sign(a_sign), .a_zero(a_zero), .a_mag(a_mag),
    .b_sign(b_sign), .b_zero(b_zero), .b_mag(b_mag),
    .lt(raw_lt), .eq(raw_eq)
  );

  always_comb begin
    flags.unord    = a_nan | b_nan;
    flags.any_nan  = a_nan | b_nan;
    flags.any_snan = a_snan | b_snan;
    flags.lt       = raw_lt & ~(a_nan | b_nan);
    flags.eq       = raw_eq & ~(a_nan | b_nan);
  end

endmodule

// File: rtl/fp_mask_compare.sv
module fp_mask_compare
  import fpcmp_pkg::*;
#(
  parameter int SGL_EXP  = 8,
  parameter int SGL_FRAC = 23,
  parameter int DBL_EXP  = 11,
  parameter int DBL_FRAC = 52,
  localparam int SGL_W   = 1 + SGL_EXP + SGL_FRAC,
  localparam int DBL_W   = 1 + DBL_EXP + DBL_FRAC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_dbl,
  input  logic [4:0]       in_code,
  input  logic [DBL_W-1:0] op_a,
  input  logic [DBL_W-1:0] op_b,
  output logic             res_valid,
  output logic             res_we,
  output logic             res_illegal,
  output logic             res_invalid,
  output logic [DBL_W-1:0] res_mask,
  output logic             invalid_sticky
);

  localparam logic [DBL_W-1:0] SGL_ONES = {{(DBL_W-SGL_W){1'b0}}, {SGL_W{1'b1}}};

  cmp_flags_t       lane_flags [2];
  cmp_flags_t       sel_flags;
  logic             legal;
  logic             hit;
  logic             inv;
  logic [DBL_W-1:0] mask_next;

  // One lane per format: index 0 single, index 1 double.
  for (genvar gi = 0; gi < 2; gi++) begin : g_fmt
    localparam int EW = (gi == 0) ? SGL_EXP  : DBL_EXP;
    localparam int FW = (gi == 0) ? SGL_FRAC : DBL_FRAC;
    localparam int LW = 1 + EW + FW;
    fpcmp_lane #(.EXP_W(EW), .FRAC_W(FW)) u_lane (
      .a(op_a[LW-1:0]),
      .b(op_b[LW-1:0]),
      .flags(lane_flags[gi])
    );
  end

  always_comb begin
    sel_flags = lane_flags[in_dbl];
    legal     = code_legal(in_code);
    hit       = eval_pred(in_code, sel_flags);
    inv       = legal && eval_invalid(in_code, sel_flags);
    if (!hit)        mask_next = '0;
    else if (in_dbl) mask_next = '1;
    else             mask_next = SGL_ONES;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid      <= 1'b0;
      res_we         <= 1'b0;
      res_illegal    <= 1'b0;
      res_invalid    <= 1'b0;
      res_mask       <= '0;
      invalid_sticky <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_we      <= legal;
        res_illegal <= !legal;
        res_invalid <= inv;
        if (legal) res_mask <= mask_next;
        if (inv) invalid_sticky <= 1'b1;
      end else begin
        res_we      <= 1'b0;
        res_illegal <= 1'b0;
        res_invalid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fpcmp_mask_checker.sv
module fpcmp_mask_checker #(
  parameter int DATA_W = 64,
  parameter int SGL_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_dbl,
  input logic [4:0]        in_code,
  input logic              res_valid,
  input logic              res_we,
  input logic              res_illegal,
  input logic              res_invalid,
  input logic [DATA_W-1:0] res_mask,
  input logic              invalid_sticky
);

  localparam logic [DATA_W-1:0] LOW_ONES = {{(DATA_W-SGL_W){1'b0}}, {SGL_W{1'b1}}};

  logic bad_code;
  assign bad_code = in_code[4] && (in_code[2] || (in_code[1:0] == 2'd0));

  p_strobe_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && !res_we && !res_illegal && !res_invalid));

  p_mask_shape_r2: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_we) |-> (res_mask == '0 || res_mask == '1 || res_mask == LOW_ONES));

  p_sgl_upper_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_dbl && !in_code[4]) |=> (res_mask[DATA_W-1:SGL_W] == '0));

  p_false_pred_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_code[4] && in_code[2:0] == 3'd0) |=> (res_mask == '0 && res_we));

  p_illegal_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && bad_code) |=> (res_illegal && !res_we && !res_invalid && $stable(res_mask)));

  p_sticky_keep_r11: assert property (@(posedge clk) disable iff (rst)
    invalid_sticky |=> invalid_sticky);

  p_sticky_set_r11: assert property (@(posedge clk) disable iff (rst)
    res_invalid |-> invalid_sticky);

endmodule

bind fp_mask_compare fpcmp_mask_checker #(.DATA_W(DBL_W), .SGL_W(SGL_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_dbl(in_dbl), .in_code(in_code),
  .res_valid(res_valid), .res_we(res_we), .res_illegal(res_illegal),
  .res_invalid(res_invalid), .res_mask(res_mask), .invalid_sticky(invalid_sticky)
);

// File: tb/fp_mask_compare_tb.sv
`timescale 1ns/1ps
module fp_mask_compare_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_dbl = 1'b0;
  logic [4:0]  in_code = '0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        res_valid, res_we, res_illegal, res_invalid, invalid_sticky;
  logic [63:0] res_mask;

  int  n_checks = 0;
  int  n_err    = 0;
  bit  done     = 1'b0;

  // Expected output state
  bit          e_valid, e_we, e_ill, e_inv, e_sticky;
  logic [63:0] e_mask = '0;

  always #4 clk = ~clk;

  fp_mask_compare dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dbl(in_dbl), .in_code(in_code),
    .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_we(res_we),
    .res_illegal(res_illegal), .res_invalid(res_invalid), .res_mask(res_mask),
    .invalid_sticky(invalid_sticky)
  );

  logic [31:0] sgl_tab [0:10] = '{32'h3F800000, 32'h40000000, 32'hBF800000, 32'hC0000000,
    32'h00000000, 32'h80000000, 32'h7FC00000, 32'h7FA00000, 32'h7F800000,
    32'h00000001, 32'hFF800000};
  logic [63:0] dbl_tab [0:10] = '{64'h3FF0000000000000, 64'h4000000000000000,
    64'hBFF0000000000000, 64'hC000000000000000, 64'h0, 64'h8000000000000000,
    64'h7FF8000000000000, 64'h7FF4000000000000, 64'h7FF0000000000000,
    64'h0000000000000001, 64'hFFF0000000000000};

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit nan_of(input bit d, input logic [63:0] x);
    if (d) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic bit snan_of(input bit d, input logic [63:0] x);
    if (d) return nan_of(d, x) && !x[51];
    return nan_of(d, x) && !x[22];
  endfunction

  function automatic real value_of(input bit d, input logic [63:0] x);
    real r;
    int  e;
    if (d) return $bitstoreal(x);
    e = int'(x[30:23]);
    if (e == 255)    r = $bitstoreal(64'h7FF0000000000000);
    else if (e == 0) r = real'(x[22:0]) * (2.0 ** (-149));
    else             r = (1.0 + real'(x[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    return x[31] ? -r : r;
  endfunction

  // One request (or idle when v=0), then compare outputs after the next edge.
  task automatic step(input bit v, input bit d, input logic [4:0] c,
                      input logic [63:0] a, input logic [63:0] b, input string tag);
    bit  un, lt, eq, gt, pred, legal, inv;
    real ra, rb;
    string itag;
    un = nan_of(d, a) || nan_of(d, b);
    ra = 0.0; rb = 0.0;
    if (!un) begin ra = value_of(d, a); rb = value_of(d, b); end
    lt = !un && (ra < rb);
    eq = !un && (ra == rb);
    gt = !un && (rb < ra);
    legal = 1'b1;
    case (int'(c))
      0, 8:   pred = 0;
      1, 9:   pred = un;
      2, 10:  pred = eq;
      3, 11:  pred = un || eq;
      4, 12:  pred = lt;
      5, 13:  pred = un || lt;
      6, 14:  pred = lt || eq;
      7, 15:  pred = un || lt || eq;
      17, 25: pred = lt || eq || gt;
      18, 26: pred = un || lt || gt;
      19, 27: pred = lt || gt;
      default: begin pred = 0; legal = 1'b0; end
    endcase
    inv = legal && (c[3] ? un : (snan_of(d, a) || snan_of(d, b)));
    e_valid = v;
    e_we  = v && legal;
    e_ill = v && !legal;
    e_inv = v && inv;
    if (e_inv) e_sticky = 1'b1;
    if (v && legal) e_mask = pred ? (d ? 64'hFFFFFFFFFFFFFFFF : 64'h00000000FFFFFFFF) : 64'h0;
    itag = c[3] ? "R9" : "R10";
    if (!legal) itag = "R8";
    in_valid = v; in_dbl = d; in_code = c; op_a = a; op_b = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(res_valid === e_valid, "R1 valid", 64'(res_valid), 64'(e_valid));
    chk(res_we === e_we, "R8 write enable", 64'(res_we), 64'(e_we));
    chk(res_illegal === e_ill, "R8 illegal", 64'(res_illegal), 64'(e_ill));
    chk(res_invalid === e_inv, itag, 64'(res_invalid), 64'(e_inv));
    chk(res_mask === e_mask, tag, res_mask, e_mask);
    chk(invalid_sticky === e_sticky, "R11 sticky", 64'(invalid_sticky), 64'(e_sticky));
  endtask

  function automatic string tag_of(input logic [4:0] c);
    if (c[4] && (c[2] || c[1:0] == 0)) return "R8 mask held";
    if (!c[4] && c[2:0] == 0) return "R5 always false";
    if (c[4]) return "R7 complement";
    if (c[0] && c[2:1] != 0) return "R6 unordered-or";
    return "R3 base predicate";
  endfunction

  initial begin
    e_valid = 0; e_we = 0; e_ill = 0; e_inv = 0; e_sticky = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13: reset state
    chk(res_valid === 1'b0, "R13 valid", 64'(res_valid), 0);
    chk(res_mask === 64'h0, "R13 mask", res_mask, 0);
    chk(invalid_sticky === 1'b0, "R13 sticky", 64'(invalid_sticky), 0);
    rst = 1'b0;
    step(0, 1, 5'd2, 0, 0, "R13 idle after reset");
    // R4: negative ordering, double and single
    step(1, 1, 5'd4, dbl_tab[3], dbl_tab[2], "R4 -2<-1 dbl");
    step(1, 0, 5'd4, {32'h0, sgl_tab[2]}, {32'h0, sgl_tab[3]}, "R4 -1<-2 sgl false");
    step(1, 1, 5'd12, dbl_tab[10], dbl_tab[9], "R4 -inf<denorm");
    // R12: upper halves differ, single compare sees equal low halves
    step(1, 0, 5'd2, {32'h12345678, sgl_tab[0]}, {32'h9ABCDEF0, sgl_tab[0]}, "R12 upper ignored");
    step(1, 0, 5'd1, {32'hFFFFFFFF, sgl_tab[0]}, {32'h7FF80000, sgl_tab[1]}, "R12 upper NaN ignored");
    // R2: single true mask leaves upper zero after a double all-ones
    step(1, 1, 5'd2, dbl_tab[0], dbl_tab[0], "R2 dbl ones");
    step(1, 0, 5'd2, {32'hDEADBEEF, sgl_tab[0]}, {32'hDEADBEEF, sgl_tab[0]}, "R2 sgl ones");
    // Sweep every code, both precisions, all operand pairs
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 32; c++) begin
        for (int i = 0; i < 11; i++) begin
          for (int j = 0; j < 11; j++) begin
            if (d == 1)
              step(1, 1, 5'(c), dbl_tab[i], dbl_tab[j], tag_of(5'(c)));
            else
              step(1, 0, 5'(c), {32'hDEADBEEF, sgl_tab[i]}, {32'h5555AAAA, sgl_tab[j]},
                   tag_of(5'(c)));
            if (((i + j + c) % 7) == 0) step(0, 0, 5'd0, 0, 0, "R1 idle gap");
          end
        end
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule